// File: doc/BRIEF.md
# Triggered Chirp Playback Engine

This block plays back one linear FM pulse on two channels, in-phase (I, cosine) and quadrature (Q, sine), each time a pulse-repetition trigger rises. The pulse is held as precomputed 14-bit samples in two on-chip ROMs. The ROM contents are computed when the design is built, from the sample rate, the sweep width and the pulse length, so no memory file is needed. With the default parameters the pulse sweeps from 0 to 50 MHz at a 250 MHz sample rate. That gives 2500 samples, or 10 µs, and a slope of 5 MHz per µs.

The trigger is an asynchronous input. It passes through a two-flop synchronizer, and its rising edge starts an address counter at zero. The counter advances once per clock up to a stop address, which is sampled when the pulse starts. Each addressed sample pair leaves a registered output stage together with a valid strobe, ready for a two-channel DAC. Between pulses both words rest at the offset-binary mid-scale code. The trigger source normally fires once per 1 ms repetition interval, which is 250000 sample clocks.

Top module: `chirp_playback`

## Requirements
- R1: While `valid_o` is low, both `i_code_o` and `q_code_o` equal the mid-scale code 8192. After reset, `valid_o` and `busy_o` are low.
- R2: A rising edge of `trig_i` is recognised through a two-flop synchronizer. If `trig_i` is first sampled high at clock edge k, `busy_o` is high after edge k+2 with the address at 0, and the first valid sample appears after edge k+3.
- R3: While busy, the address rises by exactly one per clock. `valid_o` equals `busy_o` delayed by one clock, and the sample for address n is presented one clock after the address.
- R4: A pulse covers addresses 0 through the stop address inclusive, which is stop+1 valid samples. A `stop_addr_i` above DEPTH-1 (2499) is clamped to DEPTH-1.
- R5: A trigger edge recognised while busy and not on the last address is ignored. The running pulse keeps its length.
- R6: A trigger held high produces one pulse only. A new pulse needs the trigger to go low and then high again.
- R7: `stop_addr_i` is sampled only on the clock edge that starts a pulse. Changing it during the pulse has no effect.
- R8: The sample at index n has the phase 2π·n²·B/(2·N·Fs), where B is the sweep width, N the depth and Fs the sample rate. I = 8192 + round(8191·cos(phase)) and Q = 8192 + round(8191·sin(phase)), each within ±3 codes. Sample 0 is exactly I=16383, Q=8192.
- R9: Output codes are offset binary and never leave the range 1 to 16383.
- R10: A trigger edge recognised on the clock edge that retires the last address starts the next pulse at once. `valid_o` then stays high across both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Pulse-repetition trigger, asynchronous |
| stop_addr_i | input | 12 | Last address of the pulse, sampled at pulse start |
| i_code_o | output | 14 | In-phase (cosine) DAC word, offset binary |
| q_code_o | output | 14 | Quadrature (sine) DAC word, offset binary |
| valid_o | output | 1 | High while a pulse sample is presented |
| busy_o | output | 1 | High while the address counter runs |

## Verification
The hardest situation to reach from the ports is a trigger edge that falls exactly on the clock edge retiring the last address. That edge must start the next pulse with no gap in the valid strobe. One clock earlier, the same edge must be ignored. Because the trigger is delayed by the synchronizer, the bench schedules the trigger in the clock six edges after the first trigger for a six-sample pulse. It schedules a second trigger one clock earlier to probe the ignore case. A behavioural model tracks the synchronizer delay and the pulse state every clock. Over a full clamped 2500-sample pulse, each sample is compared against real-valued cosine and sine within a small tolerance.

// File: rtl/chirp_pb_pkg.sv
package chirp_pb_pkg;

   // Phase of one sample, expressed as a fraction of a turn.
   localparam int     PH_BITS   = 16;
   localparam int     QTR_BITS  = PH_BITS - 2;
   localparam longint QTR       = longint'(1) <<< QTR_BITS;
   localparam longint PH_MOD    = longint'(1) <<< PH_BITS;
   localparam longint Q_ONE     = longint'(1) <<< 30;
   localparam longint Q_HALF_PI = 64'sd1686629713;

   // sin(x) for x in [0, pi/2], with x and the result in Q30 fixed point.
   function automatic longint poly_sin_q30(input longint x);
      longint x2;
      longint t;
      x2 = (x * x) >>> 30;
      t  = Q_ONE;
      t  = Q_ONE - ((x2 * t) >>> 30) / 110;
      t  = Q_ONE - ((x2 * t) >>> 30) / 72;
      t  = Q_ONE - ((x2 * t) >>> 30) / 42;
      t  = Q_ONE - ((x2 * t) >>> 30) / 20;
      t  = Q_ONE - ((x2 * t) >>> 30) / 6;
      return (x * t) >>> 30;
   endfunction

   // Offset-binary code of one chirp sample. cos_sel picks the cosine channel.
   function automatic int sample_code(input int idx, input int depth,
                                      input int fs_hz, input int bw_hz,
                                      input int amp, input int width,
                                      input bit cos_sel);
      longint n2;
      longint den;
      longint rem;
      longint ph;
      longint quad;
      longint r;
      longint a;
      longint s;
      longint mag;
      longint mid;
      n2   = longint'(idx) * longint'(idx);
      den  = 2 * longint'(depth) * longint'(fs_hz);
      rem  = (n2 * longint'(bw_hz)) % den;
      ph   = (rem <<< PH_BITS) / den;
      if (cos_sel) ph = (ph + QTR) % PH_MOD;
      quad = ph >>> QTR_BITS;
      r    = ph % QTR;
      a    = (quad % 2 == 1) ? (QTR - r) : r;
      s    = poly_sin_q30((a * Q_HALF_PI) >>> QTR_BITS);
      mag  = (longint'(amp) * s + (Q_ONE >>> 1)) >>> 30;
      mid  = longint'(1) <<< (width - 1);
      return int'((quad >= 2) ? (mid - mag) : (mid + mag));
   endfunction

endpackage

// File: rtl/chirp_trig_edge.sv
module chirp_trig_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic rise_o
);
   // sh[0..STAGES-1] form the synchronizer, and sh[STAGES] is the previous value.
   logic [STAGES:0] sh;

   if (STAGES < 2) begin : g_bad_stages
      $error("chirp_trig_edge: at least two synchronizer stages required");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], trig_i};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/chirp_addr_seq.sv
module chirp_addr_seq #(
   parameter int DEPTH = 2500,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] stop_i,
   output logic          active_o,
   output logic [AW-1:0] addr_o,
   output logic [AW-1:0] stop_o
);
   localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

   logic          active;
   logic [AW-1:0] addr;
   logic [AW-1:0] stop_lat;
   logic [AW-1:0] stop_clamp;
   logic          at_last;

   if (DEPTH > (1 << AW)) begin : g_bad_aw
      $error("chirp_addr_seq: AW too narrow for DEPTH");
   end

   assign stop_clamp = (stop_i > TOP_ADDR) ? TOP_ADDR : stop_i;
   assign at_last    = active && (addr == stop_lat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         addr     <= '0;
         stop_lat <= TOP_ADDR;
      end else if (active && !at_last) begin
         addr <= addr + 1'b1;
      end else if (start_i) begin
         active   <= 1'b1;
         addr     <= '0;
         stop_lat <= stop_clamp;
      end else begin
         active <= 1'b0;
      end
   end

   assign active_o = active;
   assign addr_o   = addr;
   assign stop_o   = stop_lat;
endmodule

// File: rtl/chirp_rom.sv
module chirp_rom
   import chirp_pb_pkg::*;
#(
   parameter int W         = 14,
   parameter int DEPTH     = 2500,
   parameter int AW        = $clog2(DEPTH),
   parameter int SAMPLE_HZ = 250_000_000,
   parameter int SWEEP_HZ  = 50_000_000,
   parameter int AMPLITUDE = 8191,
   parameter bit COS_SEL   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  code_o
);
   localparam logic [W-1:0] MID = W'(1 << (W - 1));

   logic [W-1:0] mem [DEPTH];
   logic [W-1:0] code_q;

   initial begin
      for (int k = 0; k < DEPTH; k++) begin
         mem[k] = W'(sample_code(k, DEPTH, SAMPLE_HZ, SWEEP_HZ,
                                 AMPLITUDE, W, COS_SEL));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= MID;
      else if (rd_en) code_q <= mem[rd_addr];
      else            code_q <= MID;
   end

   assign code_o = code_q;
endmodule

// File: rtl/chirp_playback.sv
module chirp_playback #(
   parameter int SAMPLE_W    = 14,
   parameter int DEPTH       = 2500,
   parameter int SAMPLE_HZ   = 250_000_000,
   parameter int SWEEP_HZ    = 50_000_000,
   parameter int AMPLITUDE   = 8191,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_i,
   input  logic [AW-1:0]       stop_addr_i,
   output logic [SAMPLE_W-1:0] i_code_o,
   output logic [SAMPLE_W-1:0] q_code_o,
   output logic                valid_o,
   output logic                busy_o
);
   localparam int NCH = 2;

   if (AMPLITUDE > (1 << (SAMPLE_W - 1)) - 1) begin : g_bad_amp
      $error("chirp_playback: amplitude exceeds offset-binary range");
   end
   if (2 * longint'(SWEEP_HZ) > longint'(SAMPLE_HZ)) begin : g_bad_sweep
      $error("chirp_playback: sweep end above Nyquist");
   end
   if (DEPTH < 2 || DEPTH > 65536) begin : g_bad_depth
      $error("chirp_playback: DEPTH out of supported range");
   end

   logic                rise;
   logic                active;
   logic [AW-1:0]       rd_addr;
   logic [AW-1:0]       stop_lat;
   logic                valid_q;
   logic [SAMPLE_W-1:0] ch_code [NCH];

   chirp_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .rise_o (rise)
   );

   chirp_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (rise),
      .stop_i   (stop_addr_i),
      .active_o (active),
      .addr_o   (rd_addr),
      .stop_o   (stop_lat)
   );

   // Channel 0 carries the cosine (I) and channel 1 the sine (Q).
   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      chirp_rom #(
         .W         (SAMPLE_W),
         .DEPTH     (DEPTH),
         .AW        (AW),
         .SAMPLE_HZ (SAMPLE_HZ),
         .SWEEP_HZ  (SWEEP_HZ),
         .AMPLITUDE (AMPLITUDE),
         .COS_SEL   (ch == 0)
      ) u_rom (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_en   (active),
         .rd_addr (rd_addr),
         .code_o  (ch_code[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= active;
   end

   assign i_code_o = ch_code[0];
   assign q_code_o = ch_code[1];
   assign valid_o  = valid_q;
   assign busy_o   = active;
endmodule

// File: rtl/chirp_playback_chk.sv
module chirp_playback_chk #(
   parameter int W  = 14,
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          valid,
   input logic [W-1:0]  i_code,
   input logic [W-1:0]  q_code,
   input logic [AW-1:0] addr,
   input logic [AW-1:0] stop_lat
);
   localparam logic [W-1:0] MID = W'(1 << (W - 1));

   a_r1_idle_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (i_code == MID && q_code == MID));

   a_r3_valid_lags_busy: assert property (@(posedge clk) disable iff (!rst_n)
      valid == $past(busy));

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr != stop_lat) |=> (busy && addr == $past(addr) + 1'b1));

   a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> addr == '0);

   a_r4_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> addr <= stop_lat);

   a_r7_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr != stop_lat) |=> $stable(stop_lat));

   a_r9_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (i_code != '0 && q_code != '0));
endmodule

bind chirp_playback chirp_playback_chk #(.W(SAMPLE_W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy_o),
   .valid    (valid_o),
   .i_code   (i_code_o),
   .q_code   (q_code_o),
   .addr     (rd_addr),
   .stop_lat (stop_lat)
);

// File: tb/chirp_playback_bench.sv
`timescale 1ns/1ps
module chirp_playback_bench;
   localparam int W     = 14;
   localparam int DEPTH = 2500;
   localparam int AW    = 12;
   localparam int FS    = 250_000_000;
   localparam int BW    = 50_000_000;
   localparam int AMP   = 8191;
   localparam int MID   = 8192;
   localparam int TOL   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic [AW-1:0] stop = '0;
   logic [W-1:0]  i_code;
   logic [W-1:0]  q_code;
   logic          valid;
   logic          busy;

   chirp_playback u_chirp_playback (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .stop_addr_i (stop),
      .i_code_o    (i_code),
      .q_code_o    (q_code),
      .valid_o     (valid),
      .busy_o      (busy)
   );

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_err    = 0;

   // Behavioural reference state.
   bit m_s1, m_s2, m_prev;
   bit m_active;
   int m_addr, m_stop;
   bit m_valid;
   int m_vidx;

   // Observed statistics for each scenario.
   int seen_valid, run, max_run, tick_no, first_valid_tick;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_code(input int n, input bit cos_sel);
      real turns, ph, v;
      turns = (real'(n) * real'(n) * real'(BW)) / (2.0 * real'(DEPTH) * real'(FS));
      ph    = 2.0 * 3.14159265358979 * (turns - $floor(turns));
      v     = cos_sel ? $cos(ph) : $sin(ph);
      return MID + int'(real'(AMP) * v);
   endfunction

   function automatic int absdiff(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic clear_stats();
      seen_valid = 0; run = 0; max_run = 0; tick_no = 0; first_valid_tick = -1;
   endtask

   task automatic tick(input bit t, input int stp);
      bit rise;
      int ei, eq;
      trig = t;
      stop = stp[AW-1:0];
      @(posedge clk);
      rise   = m_s2 && !m_prev;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = t;
      m_valid = m_active;
      m_vidx  = m_addr;
      if (m_active && m_addr != m_stop) m_addr++;
      else if (rise) begin
         m_active = 1'b1;
         m_addr   = 0;
         m_stop   = (stp > DEPTH - 1) ? DEPTH - 1 : stp;
      end else m_active = 1'b0;
      #2;
      tick_no++;
      check(valid == m_valid, "R3", "valid", int'(valid), int'(m_valid));
      check(busy == m_active, "R2", "busy", int'(busy), int'(m_active));
      if (valid) begin
         seen_valid++; run++;
         if (run > max_run) max_run = run;
         if (first_valid_tick < 0) first_valid_tick = tick_no;
         check(i_code != 0 && q_code != 0, "R9", "code range", int'(i_code), 1);
      end else run = 0;
      if (m_valid) begin
         ei = exp_code(m_vidx, 1'b1);
         eq = exp_code(m_vidx, 1'b0);
         check(absdiff(int'(i_code), ei) <= TOL, "R8", "I sample", int'(i_code), ei);
         check(absdiff(int'(q_code), eq) <= TOL, "R8", "Q sample", int'(q_code), eq);
         if (m_vidx == 0) begin
            check(i_code == 16383, "R8", "I sample 0", int'(i_code), 16383);
            check(q_code == MID, "R8", "Q sample 0", int'(q_code), MID);
         end
      end else begin
         check(i_code == MID, "R1", "idle I", int'(i_code), MID);
         check(q_code == MID, "R1", "idle Q", int'(q_code), MID);
      end
   endtask

   task automatic idle(input int n, input int stp);
      for (int k = 0; k < n; k++) tick(1'b0, stp);
   endtask

   initial begin
      #(20000 * 10);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check(valid == 1'b0, "R1", "reset valid", int'(valid), 0);
      check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
      check(i_code == MID, "R1", "reset I", int'(i_code), MID);
      check(q_code == MID, "R1", "reset Q", int'(q_code), MID);
      rst_n = 1'b1;
      idle(3, 0);

      // R2, R4: single pulse of ten samples, first valid on the fourth tick.
      clear_stats();
      tick(1'b1, 9);
      idle(20, 9);
      check(first_valid_tick == 4, "R2", "first valid tick", first_valid_tick, 4);
      check(seen_valid == 10, "R4", "pulse length stop=9", seen_valid, 10);

      // R7: stop changed while the pulse runs.
      clear_stats();
      tick(1'b1, 20);
      idle(5, 20);
      idle(30, 3);
      check(seen_valid == 21, "R7", "stop change mid-pulse", seen_valid, 21);

      // R5: a retrigger mid-pulse, then one on the edge before the last address.
      clear_stats();
      tick(1'b1, 7);
      idle(3, 7);
      tick(1'b1, 7);
      idle(20, 7);
      check(seen_valid == 8, "R5", "mid-pulse retrigger", seen_valid, 8);
      clear_stats();
      tick(1'b1, 5);
      idle(4, 5);
      tick(1'b1, 5);
      idle(20, 5);
      check(seen_valid == 6, "R5", "retrigger before last", seen_valid, 6);

      // R6: trigger held high.
      clear_stats();
      for (int k = 0; k < 40; k++) tick(1'b1, 4);
      idle(10, 4);
      check(seen_valid == 5, "R6", "held trigger", seen_valid, 5);

      // R10: edge recognised on the last address gives back-to-back pulses.
      clear_stats();
      tick(1'b1, 5);
      idle(5, 5);
      tick(1'b1, 5);
      idle(20, 5);
      check(seen_valid == 12, "R10", "back-to-back total", seen_valid, 12);
      check(max_run == 12, "R10", "back-to-back run", max_run, 12);

      // R4: stop of zero gives one sample.
      clear_stats();
      tick(1'b1, 0);
      idle(10, 0);
      check(seen_valid == 1, "R4", "stop=0 length", seen_valid, 1);

      // R4, R8: stop above the depth is clamped, so the full pulse plays.
      clear_stats();
      tick(1'b1, 4095);
      idle(DEPTH + 10, 4095);
      check(seen_valid == DEPTH, "R4", "clamped full pulse", seen_valid, DEPTH);
      check(max_run == DEPTH, "R4", "full pulse continuous", max_run, DEPTH);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule